// File: doc/BRIEF.md
# DRAM Compressed Test Mode Controller

This block is a cycle-based, synthesizable model of the control and data path of a by-one dynamic memory that supports a compressed parallel test mode. It samples the active-low row strobe, column strobe and write enable on a system clock. It finds strobe edges and classifies every row cycle from the order of the strobes. The classes are a normal access, a column-before-row refresh, a write-enable-and-column-before-row cycle that arms test mode, and a row-only refresh. A small register array stands in for the cell matrix.

In normal operation an early write stores the data input in one cell, and a read returns that cell on the data output. In test mode four column bits no longer select a cell. A write then fills all sixteen cells of a lane group with the data input bit. A read reports a single pass/fail bit: high when the sixteen cells agree, low when they differ. Every refresh shows up on the refresh strobe together with the row it refreshed. A column-before-row refresh takes its row from an internal counter. A row-only refresh takes the latched row.

Top module: `dram_ptest`

## Requirements
- R1: After reset, test mode is off, the refresh counter is zero, and both the data output enable and the refresh strobe are low.
- R2: The row address is captured at the row-strobe falling edge and the column address at the column-strobe falling edge. Outside test mode an early write stores din in the cell selected by row bits 1:0, column bit 2 and column bits 11, 10, 1 and 0. A later read of that cell returns the stored value.
- R3: A row-strobe fall while both the column strobe and write enable are low turns test mode on.
- R4: In test mode, a write stores din in all 16 cells that share row bits 1:0 and column bit 2, whatever the values on column bits 0, 1, 10 and 11.
- R5: In test mode a read drives dout high when the 16 cells of the group all hold the same value and low when they differ. Column bits 0, 1, 10 and 11 do not change the result.
- R6: A row-strobe fall with the column strobe low and write enable high turns test mode off. It pulses the refresh strobe one clock later with the current counter value on the refresh row, and the 12-bit counter then increments and wraps from 4095 to 0.
- R7: A row cycle that ends with no column-strobe fall is a row-only refresh. It turns test mode off and pulses the refresh strobe one clock after the row strobe rises, with the latched row on the refresh row.
- R8: The test-mode entry cycle also refreshes from the counter and advances it. Repeating it while in test mode keeps test mode on.
- R9: The output enable rises on the clock after a column-strobe fall in a read cycle and falls on the clock after the column or row strobe rises. It stays low through an early write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data or test pass/fail bit; zero when not enabled |
| dout_en | output | 1 | High while dout is driven; low means high impedance |
| test_active | output | 1 | Test-mode flag |
| rfsh_stb | output | 1 | One-clock pulse per refresh |
| rfsh_row | output | 12 | Row refreshed by the last refresh |

## Verification
The test-mode entry cycle does two jobs on one clock edge: it refreshes a row from the counter and sets or holds the test-mode flag. The bench issues it once from normal mode and once from inside test mode. Each time it checks that the counter row appears on the refresh outputs and advances, and that the flag is set afterwards. A second overlap is a test-mode write that overwrites a group made unequal by an earlier normal write. Reading back through several lane addresses shows whether all 16 cells were replaced on the same edge.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;
  parameter int ADDR_W    = 12;
  parameter int ROW_SEL_W = 2;
  parameter int GRP_COL_W = 1;
  parameter int GRP_COL_LO = 2;
  parameter int LANE_W    = 4;
  parameter int GRP_W     = ROW_SEL_W + GRP_COL_W;
  parameter int IDX_W     = GRP_W + LANE_W;
  parameter int LANES     = 1 << LANE_W;
  parameter int CELLS     = 1 << IDX_W;

  typedef enum logic [1:0] {CYC_IDLE, CYC_ROW, CYC_RFSH} cyc_e;

  // Column bits that pick a cell inside a group; ignored in test mode.
  function automatic logic [LANE_W-1:0] lane_of(input logic [ADDR_W-1:0] col);
    return {col[ADDR_W-1], col[ADDR_W-2], col[1], col[0]};
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] row,
                                               input logic [ADDR_W-1:0] col);
    return {row[ROW_SEL_W-1:0], col[GRP_COL_LO +: GRP_COL_W]};
  endfunction

  function automatic logic [IDX_W-1:0] cell_idx(input logic [ADDR_W-1:0] row,
                                                input logic [ADDR_W-1:0] col);
    return {grp_of(row, col), lane_of(col)};
  endfunction

  function automatic logic all_agree(input logic [LANES-1:0] g);
    return (&g) | ~(|g);
  endfunction
endpackage

// File: rtl/ptest_strobe_decode.sv
module ptest_strobe_decode
  import dram_ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cbr_evt,
  output logic              wcbr_evt,
  output logic              rasonly_evt,
  output logic              wr_evt,
  output logic              rd_act,
  output logic [ADDR_W-1:0] row_l,
  output logic [ADDR_W-1:0] col_l
);
  logic ras_q, cas_q, col_seen, early_wr;
  cyc_e cyc;
  logic ras_fall, ras_rise, cas_fall, cas_rise, col_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign col_fall = cas_fall & ~ras_n & (cyc == CYC_ROW) & ~ras_fall;

  assign cbr_evt     = ras_fall & ~cas_n & we_n;
  assign wcbr_evt    = ras_fall & ~cas_n & ~we_n;
  assign rasonly_evt = ras_rise & (cyc == CYC_ROW) & ~col_seen;
  assign wr_evt      = col_fall & ~we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      cyc      <= CYC_IDLE;
      col_seen <= 1'b0;
      early_wr <= 1'b0;
      rd_act   <= 1'b0;
      row_l    <= '0;
      col_l    <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        rd_act   <= 1'b0;
        early_wr <= 1'b0;
        if (!cas_n) begin
          cyc <= CYC_RFSH;
        end else begin
          cyc      <= CYC_ROW;
          row_l    <= addr;
          col_seen <= 1'b0;
        end
      end else if (ras_rise) begin
        cyc      <= CYC_IDLE;
        rd_act   <= 1'b0;
        early_wr <= 1'b0;
      end else if (col_fall) begin
        col_seen <= 1'b1;
        col_l    <= addr;
        rd_act   <= we_n;
        early_wr <= ~we_n;
      end else if (cas_rise) begin
        rd_act   <= 1'b0;
        early_wr <= 1'b0;
      end
    end
  end

  // R9: an early write cycle never enables the output
  a_r9_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    early_wr |-> !rd_act);
  // R9: output only enabled inside a normal row cycle with the row strobe low
  a_r9_read_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> (cyc == CYC_ROW) && !ras_q);
  // R7: refresh kinds are exclusive
  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cbr_evt, wcbr_evt, rasonly_evt, wr_evt}) <= 1);
endmodule

// File: rtl/ptest_mode_ctrl.sv
module ptest_mode_ctrl
  import dram_ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbr_evt,
  input  logic              wcbr_evt,
  input  logic              rasonly_evt,
  input  logic [ADDR_W-1:0] row_l,
  output logic              test_mode,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic [ADDR_W-1:0] rfsh_cnt
);
  logic cnt_refresh;
  assign cnt_refresh = cbr_evt | wcbr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_mode <= 1'b0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      rfsh_cnt  <= '0;
    end else if (cnt_refresh) begin
      rfsh_stb  <= 1'b1;
      rfsh_row  <= rfsh_cnt;
      rfsh_cnt  <= rfsh_cnt + 1'b1;
      test_mode <= wcbr_evt;
    end else if (rasonly_evt) begin
      rfsh_stb  <= 1'b1;
      rfsh_row  <= row_l;
      test_mode <= 1'b0;
    end else begin
      rfsh_stb  <= 1'b0;
    end
  end

  a_r3_wcbr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wcbr_evt |=> test_mode);
  a_r6_cbr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> !test_mode);
  a_r7_rasonly_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rasonly_evt |=> !test_mode && rfsh_stb);
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_refresh |=> rfsh_cnt == ADDR_W'($past(rfsh_cnt) + 1'b1));
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_refresh || rasonly_evt) |=> $stable(test_mode) && !rfsh_stb);
endmodule

// File: rtl/ptest_cell_array.sv
module ptest_cell_array
  import dram_ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              wr_evt,
  input  logic              din,
  input  logic [ADDR_W-1:0] wr_row,
  input  logic [ADDR_W-1:0] wr_col,
  input  logic [ADDR_W-1:0] rd_row,
  input  logic [ADDR_W-1:0] rd_col,
  output logic              rd_bit
);
  logic [CELLS-1:0] mem;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [LANES-1:0] rd_group_bits;

  assign wr_grp        = grp_of(wr_row, wr_col);
  assign rd_grp        = grp_of(rd_row, rd_col);
  assign rd_group_bits = mem[rd_grp*LANES +: LANES];
  assign rd_bit = test_mode ? all_agree(rd_group_bits)
                            : mem[cell_idx(rd_row, rd_col)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_evt) begin
      if (test_mode) mem[wr_grp*LANES +: LANES] <= {LANES{din}};
      else           mem[cell_idx(wr_row, wr_col)] <= din;
    end
  end

  // R4: a test write leaves its whole group equal to din
  a_r4_group_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && test_mode) |=> mem[$past(wr_grp)*LANES +: LANES] == {LANES{$past(din)}});
  // R2: a normal write lands in exactly the addressed cell
  a_r2_cell_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !test_mode) |=> mem[$past(cell_idx(wr_row, wr_col))] == $past(din));
endmodule

// File: rtl/dram_ptest.sv
module dram_ptest
  import dram_ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              test_active,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row
);
  logic              cbr_evt, wcbr_evt, rasonly_evt, wr_evt, rd_act, rd_bit;
  logic [ADDR_W-1:0] row_l, col_l, rfsh_cnt;

  ptest_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cbr_evt(cbr_evt), .wcbr_evt(wcbr_evt),
    .rasonly_evt(rasonly_evt), .wr_evt(wr_evt), .rd_act(rd_act),
    .row_l(row_l), .col_l(col_l)
  );

  ptest_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .cbr_evt(cbr_evt), .wcbr_evt(wcbr_evt),
    .rasonly_evt(rasonly_evt), .row_l(row_l), .test_mode(test_active),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .rfsh_cnt(rfsh_cnt)
  );

  ptest_cell_array u_arr (
    .clk(clk), .rst_n(rst_n), .test_mode(test_active), .wr_evt(wr_evt),
    .din(din), .wr_row(row_l), .wr_col(addr), .rd_row(row_l), .rd_col(col_l),
    .rd_bit(rd_bit)
  );

  assign dout_en = rd_act;
  assign dout    = rd_act & rd_bit;

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> !test_active && !dout_en && !rfsh_stb && rfsh_cnt == '0);
  // R9: output drive ends the clock after the column strobe rises
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && cas_n) |=> !dout_en);
endmodule

// File: tb/dram_ptest_test.sv
`timescale 1ns/1ps
module dram_ptest_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic dout, dout_en, test_active, rfsh_stb;
  logic [11:0] rfsh_row;
  int checks = 0, errors = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  dram_ptest uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .test_active(test_active), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] row, input logic [11:0] col, input logic d);
    @(negedge clk); ras_n = 0; addr = row;
    @(negedge clk); cas_n = 0; we_n = 0; addr = col; din = d;
    @(negedge clk); chk(dout_en == 0, "R9 early write", dout_en, 0);
    ras_n = 1; cas_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] row, input logic [11:0] col, output logic d);
    @(negedge clk); ras_n = 0; addr = row;
    @(negedge clk); cas_n = 0; we_n = 1; addr = col;
    @(negedge clk); chk(dout_en == 1, "R9 read enable", dout_en, 1);
    d = dout;
    ras_n = 1; cas_n = 1;
    @(negedge clk); chk(dout_en == 0, "R9 release", dout_en, 0);
  endtask

  task automatic do_cbr(input logic we, input logic exp_test);
    @(negedge clk); cas_n = 0; we_n = we;
    @(negedge clk); ras_n = 0;
    @(negedge clk);
    chk(rfsh_stb == 1, we ? "R6 strobe" : "R8 strobe", rfsh_stb, 1);
    chk(rfsh_row == 12'(exp_cnt), we ? "R6 counter row" : "R8 counter row", rfsh_row, exp_cnt);
    chk(test_active == exp_test, we ? "R6 mode" : "R3 mode", test_active, exp_test);
    exp_cnt = (exp_cnt + 1) % 4096;
    ras_n = 1; cas_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic do_ras_only(input logic [11:0] row);
    @(negedge clk); ras_n = 0; addr = row;
    @(negedge clk); ras_n = 1;
    @(negedge clk);
    chk(rfsh_stb == 1, "R7 strobe", rfsh_stb, 1);
    chk(rfsh_row == row, "R7 row", rfsh_row, row);
    chk(test_active == 0, "R7 mode", test_active, 0);
  endtask

  task automatic t_reset;
    chk(test_active == 0, "R1 test mode", test_active, 0);
    chk(dout_en == 0, "R1 dout_en", dout_en, 0);
    chk(rfsh_stb == 0, "R1 strobe", rfsh_stb, 0);
  endtask

  task automatic t_normal;
    logic d;
    do_write(12'h001, 12'h005, 1'b1);
    do_write(12'h001, 12'h004, 1'b0);
    do_write(12'h003, 12'h800, 1'b1);
    do_read(12'h001, 12'h005, d); chk(d == 1, "R2 read a", d, 1);
    do_read(12'h001, 12'h004, d); chk(d == 0, "R2 read b", d, 0);
    do_read(12'h003, 12'h800, d); chk(d == 1, "R2 read c", d, 1);
    do_read(12'h003, 12'h000, d); chk(d == 0, "R2 neighbour", d, 0);
  endtask

  task automatic t_refresh;
    do_cbr(1'b1, 1'b0);
    do_cbr(1'b1, 1'b0);
    do_ras_only(12'h123);
  endtask

  task automatic t_test_mode;
    logic d;
    do_cbr(1'b0, 1'b1);                  // R3 entry, also R8 refresh
    do_write(12'h002, 12'h000, 1'b1);    // R4 group {row 2, CA2=0}
    do_read(12'h002, 12'h000, d); chk(d == 1, "R5 equal ones", d, 1);
    do_read(12'h002, 12'hC03, d); chk(d == 1, "R5 lane bits ignored", d, 1);
    do_cbr(1'b1, 1'b0);                  // R6 exit
    do_read(12'h002, 12'hC03, d); chk(d == 1, "R4 far lane filled", d, 1);
    do_read(12'h002, 12'h401, d); chk(d == 1, "R4 mid lane filled", d, 1);
    do_write(12'h002, 12'h001, 1'b0);    // break the group
    do_cbr(1'b0, 1'b1);
    do_read(12'h002, 12'h000, d); chk(d == 0, "R5 differ", d, 0);
    do_write(12'h002, 12'h802, 1'b0);    // R4 lane bits 11,1 set but ignored
    do_read(12'h002, 12'h001, d); chk(d == 1, "R5 equal zeros", d, 1);
    do_cbr(1'b0, 1'b1);                  // R8 WCBR inside test mode
    do_ras_only(12'h002);                // R7 exit
    do_read(12'h002, 12'h000, d); chk(d == 0, "R4 lane 0 cleared", d, 0);
  endtask

  task automatic t_wrap;
    while (exp_cnt != 4095) do_cbr(1'b1, 1'b0);
    do_cbr(1'b1, 1'b0);                  // row 4095
    do_cbr(1'b1, 1'b0);                  // R6 wrap: row 0
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_refresh();
    t_test_mode();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule